// File: doc/BRIEF.md
# Refresh Scheduler with Partial-Array Self Refresh

This block paces the periodic auto-refresh traffic of a synchronous DRAM controller and owns the decision to put the memory into self refresh and bring it back out. A free-running interval timer produces one refresh obligation per refresh interval. Obligations the controller cannot serve at once are counted as debt and presented back-to-back through a request/grant handshake until the debt is cleared.

Self refresh is entered on request once no refresh is owed. The block holds the memory clock enable low for as long as self refresh lasts. On a wake request it raises the clock enable again and owes exactly one refresh before normal pacing resumes. A separate retention setting, written through an extended-mode write, selects which banks stay refreshed during self refresh: all four, the two with bank-address bit 1 clear, or bank 0 alone. The result is presented as a bank mask. A setting written while banks are busy waits until every bank is idle.

Top module: `refresh_sched`

## Requirements
- R1: With no grants, `ref_req` first rises after exactly `INTERVAL` rising clock edges following reset release, and one new obligation is added every `INTERVAL` edges while not in self refresh.
- R2: Each edge with `ref_grant` high while `ref_req` is high retires one obligation; `ref_req` stays high across consecutive grants until the owed count reaches zero and falls on the edge that retires the last one.
- R3: The owed count saturates at `MAX_DEBT` (default 8); further interval ticks while saturated are lost, so after 12 intervals without grants exactly 8 grants clear the request.
- R4: `ref_grant` while `ref_req` is low has no effect on the owed count.
- R5: `sr_req` sampled high while nothing is owed drives `cke` low after that edge; while a refresh is owed, entry waits until the owed count has been cleared.
- R6: While in self refresh `ref_req` is low and no obligations accumulate, however long the stay.
- R7: `wake_req` during self refresh drives `cke` high and `ref_req` high after the same edge; a single grant clears that request and the next interval tick follows `INTERVAL` edges after the wake edge.
- R8: The retention code is `xm_code[2:0]`; `keep_mask[i]` is the bank whose bank address {BA1,BA0} equals i. Code 000 gives 1111, 001 gives 0011 (banks with BA1=0), 010 gives 0001 (bank BA1=0, BA0=0); every other code gives 1111.
- R9: After reset `ref_req` is 0, `cke` is 1 and `keep_mask` is 1111 (full array) until a retention write takes effect.
- R10: A retention write made while `banks_idle` is low leaves `keep_mask` unchanged and is applied on the first edge at which `banks_idle` is high; a later write made before that replaces the held one.
- R11: The temperature-compensation field `xm_code[4:3]` is ignored: it never affects `keep_mask`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ref_grant | input | 1 | Controller has issued one auto-refresh |
| sr_req | input | 1 | Request to enter self refresh |
| wake_req | input | 1 | Request to leave self refresh |
| banks_idle | input | 1 | All banks are precharged and idle |
| xm_wr | input | 1 | Extended-mode write strobe |
| xm_code | input | 5 | Extended-mode field: [2:0] retention code, [4:3] temperature code |
| ref_req | output | 1 | An auto-refresh is owed |
| cke | output | 1 | Memory clock enable, low during self refresh |
| keep_mask | output | 4 | Banks retained during self refresh, bit i is bank {BA1,BA0}=i |

## Verification
The hardest state to reach is a saturated owed count, because it needs more than `MAX_DEBT` interval ticks to pass with every grant withheld and then an exact count of grants to show that the overflow was dropped rather than wrapped. The bench shortens the interval through the parameter, waits twelve intervals with the grant held low and then holds the grant for seven edges and then an eighth, watching `ref_req` fall exactly on the eighth. A second awkward case is a self-refresh request that arrives while a refresh is owed; the stimulus lets one tick land, raises the request, and grants the refresh while the request stays high to show that entry follows only the retirement.

// File: rtl/rs_pkg.sv
package rs_pkg;

  // Retention code carried in xm_code[2:0]
  typedef enum logic [2:0] {
    KEEP_ALL     = 3'b000,
    KEEP_HALF    = 3'b001,
    KEEP_QUARTER = 3'b010
  } keep_code_e;

  // Scheduler operating state
  typedef enum logic {
    ST_RUN  = 1'b0,
    ST_SELF = 1'b1
  } sched_state_e;

  localparam int unsigned XM_WIDTH   = 5;
  localparam int unsigned CODE_WIDTH = 3;

endpackage

// File: rtl/rs_interval_timer.sv
module rs_interval_timer #(
  parameter int unsigned INTERVAL = 780
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic restart,
  output logic tick
);

  localparam int unsigned CW   = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;
  localparam logic [CW-1:0] LAST = CW'(INTERVAL - 1);

  logic [CW-1:0] count_q;

  assign tick = run && (count_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      count_q <= '0;
    end else if (run) begin
      if (count_q == LAST) count_q <= '0;
      else                 count_q <= count_q + 1'b1;
    end
  end

endmodule

// File: rtl/rs_debt_counter.sv
module rs_debt_counter #(
  parameter int unsigned MAX_DEBT = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic add,
  input  logic take,
  input  logic load_one,
  output logic owed_next
);

  localparam int unsigned DW = $clog2(MAX_DEBT + 1);
  localparam logic [DW-1:0] CAP = DW'(MAX_DEBT);

  logic [DW-1:0] debt_q;
  logic [DW-1:0] debt_n;
  logic          grow;
  logic          shrink;

  // a tick at the cap still fits when one refresh leaves in the same cycle
  assign grow   = add && ((debt_q != CAP) || take);
  assign shrink = take && (debt_q != '0);

  always_comb begin
    debt_n = debt_q;
    if (load_one) begin
      debt_n = DW'(1);
    end else begin
      unique case ({grow, shrink})
        2'b10:   debt_n = debt_q + 1'b1;
        2'b01:   debt_n = debt_q - 1'b1;
        default: debt_n = debt_q;
      endcase
    end
  end

  assign owed_next = (debt_n != '0);

  always_ff @(posedge clk) begin
    if (rst) debt_q <= '0;
    else     debt_q <= debt_n;
  end

endmodule

// File: rtl/rs_retention_reg.sv
module rs_retention_reg
  import rs_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [CODE_WIDTH-1:0] wr_code,
  input  logic                  idle,
  output logic [NUM_BANKS-1:0]  mask
);

  localparam int unsigned HALF_N    = NUM_BANKS / 2;
  localparam int unsigned QUARTER_N = NUM_BANKS / 4;

  logic                  held_q;
  logic [CODE_WIDTH-1:0] held_code_q;
  logic [CODE_WIDTH-1:0] pick_code;
  logic                  apply;
  logic [NUM_BANKS-1:0]  mask_n;
  logic [NUM_BANKS-1:0]  mask_q;

  // the newest write wins over one still waiting
  assign pick_code = wr_en ? wr_code : held_code_q;
  assign apply     = (wr_en || held_q) && idle;

  // bank b is retained when its index lies below the retained count;
  // low indices are the banks whose upper bank-address bits are clear
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    always_comb begin
      unique case (pick_code)
        KEEP_HALF:    mask_n[b] = (b < HALF_N);
        KEEP_QUARTER: mask_n[b] = (b < QUARTER_N);
        default:      mask_n[b] = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      held_q      <= 1'b0;
      held_code_q <= KEEP_ALL;
      mask_q      <= '1;
    end else begin
      if (apply) begin
        mask_q <= mask_n;
        held_q <= 1'b0;
      end else if (wr_en) begin
        held_q      <= 1'b1;
        held_code_q <= wr_code;
      end
    end
  end

  assign mask = mask_q;

endmodule

// File: rtl/refresh_sched.sv
module refresh_sched
  import rs_pkg::*;
#(
  parameter int unsigned INTERVAL  = 780,
  parameter int unsigned MAX_DEBT  = 8,
  parameter int unsigned NUM_BANKS = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ref_grant,
  input  logic                 sr_req,
  input  logic                 wake_req,
  input  logic                 banks_idle,
  input  logic                 xm_wr,
  input  logic [4:0]           xm_code,
  output logic                 ref_req,
  output logic                 cke,
  output logic [NUM_BANKS-1:0] keep_mask
);

  sched_state_e state_q;
  sched_state_e state_n;
  logic         tick;
  logic         take;
  logic         enter;
  logic         leave;
  logic         owed_next;
  logic         ref_req_q;
  logic         cke_q;

  assign take  = ref_grant && ref_req_q;
  assign enter = (state_q == ST_RUN) && sr_req && !ref_req_q && !tick;
  assign leave = (state_q == ST_SELF) && wake_req;

  always_comb begin
    state_n = state_q;
    if (enter)      state_n = ST_SELF;
    else if (leave) state_n = ST_RUN;
  end

  rs_interval_timer #(
    .INTERVAL (INTERVAL)
  ) u_timer (
    .clk     (clk),
    .rst     (rst),
    .run     (state_q == ST_RUN),
    .restart (leave),
    .tick    (tick)
  );

  rs_debt_counter #(
    .MAX_DEBT (MAX_DEBT)
  ) u_debt (
    .clk       (clk),
    .rst       (rst),
    .add       (tick),
    .take      (take),
    .load_one  (leave),
    .owed_next (owed_next)
  );

  rs_retention_reg #(
    .NUM_BANKS (NUM_BANKS)
  ) u_keep (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (xm_wr),
    .wr_code (xm_code[CODE_WIDTH-1:0]),
    .idle    (banks_idle),
    .mask    (keep_mask)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_RUN;
      ref_req_q <= 1'b0;
      cke_q     <= 1'b1;
    end else begin
      state_q   <= state_n;
      ref_req_q <= owed_next && (state_n == ST_RUN);
      cke_q     <= (state_n == ST_RUN);
    end
  end

  assign ref_req = ref_req_q;
  assign cke     = cke_q;

endmodule

// File: rtl/rs_checker.sv
module rs_checker #(
  parameter int unsigned NUM_BANKS = 4
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 ref_grant,
  input logic                 sr_req,
  input logic                 wake_req,
  input logic                 banks_idle,
  input logic                 ref_req,
  input logic                 cke,
  input logic [NUM_BANKS-1:0] keep_mask
);

  // R6: no refresh is requested while the clock enable is low
  p_quiet_in_self_r6: assert property (@(posedge clk) disable iff (rst)
    !cke |-> !ref_req);

  // R5: the clock enable only falls after a request with nothing owed
  p_entry_clean_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(cke) |-> ($past(sr_req) && !$past(ref_req)));

  // R7: leaving self refresh always owes one refresh
  p_wake_refresh_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(cke) |-> ref_req);

  // R2: in normal operation a request is only withdrawn by a grant
  p_drop_by_grant_r2: assert property (@(posedge clk) disable iff (rst)
    ($fell(ref_req) && cke) |-> $past(ref_grant));

  // R10: the retained set does not move while banks are busy
  p_hold_busy_r10: assert property (@(posedge clk) disable iff (rst)
    !banks_idle |=> $stable(keep_mask));

  // R8: only the three legal retention shapes appear
  p_mask_shape_r8: assert property (@(posedge clk) disable iff (rst)
    (keep_mask == '1) || (keep_mask == NUM_BANKS'((1 << (NUM_BANKS/2)) - 1))
      || (keep_mask == NUM_BANKS'((1 << (NUM_BANKS/4)) - 1)));

endmodule

bind refresh_sched rs_checker #(.NUM_BANKS(NUM_BANKS)) u_rs_checker (
  .clk        (clk),
  .rst        (rst),
  .ref_grant  (ref_grant),
  .sr_req     (sr_req),
  .wake_req   (wake_req),
  .banks_idle (banks_idle),
  .ref_req    (ref_req),
  .cke        (cke),
  .keep_mask  (keep_mask)
);

// File: tb/test_refresh_sched.sv
module test_refresh_sched;

  localparam int unsigned IV = 20;

  logic       clk = 1'b0;
  logic       rst;
  logic       ref_grant, sr_req, wake_req, banks_idle, xm_wr;
  logic [4:0] xm_code;
  logic       ref_req, cke;
  logic [3:0] keep_mask;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  refresh_sched #(.INTERVAL(IV), .MAX_DEBT(8), .NUM_BANKS(4)) i_refresh_sched (
    .clk(clk), .rst(rst), .ref_grant(ref_grant), .sr_req(sr_req),
    .wake_req(wake_req), .banks_idle(banks_idle), .xm_wr(xm_wr),
    .xm_code(xm_code), .ref_req(ref_req), .cke(cke), .keep_mask(keep_mask)
  );

  // {xm_wr, xm_code[4:0], banks_idle, expected keep_mask}
  localparam logic [10:0] ROWS [13] = '{
    {1'b0, 5'b00000, 1'b1, 4'b1111},
    {1'b1, 5'b00001, 1'b1, 4'b0011},
    {1'b1, 5'b00010, 1'b1, 4'b0001},
    {1'b1, 5'b00000, 1'b1, 4'b1111},
    {1'b1, 5'b00010, 1'b0, 4'b1111},
    {1'b0, 5'b00000, 1'b0, 4'b1111},
    {1'b0, 5'b00000, 1'b1, 4'b0001},
    {1'b1, 5'b00111, 1'b1, 4'b1111},
    {1'b1, 5'b11001, 1'b1, 4'b0011},
    {1'b1, 5'b11010, 1'b0, 4'b0011},
    {1'b1, 5'b00000, 1'b0, 4'b0011},
    {1'b0, 5'b00000, 1'b1, 4'b1111},
    {1'b1, 5'b10010, 1'b1, 4'b0001}
  };

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    rst = 1'b1; ref_grant = 0; sr_req = 0; wake_req = 0;
    banks_idle = 1'b1; xm_wr = 0; xm_code = '0;
    step(3);
    check("R9 ref_req in reset", ref_req, 0);
    check("R9 cke in reset", cke, 1);
    check("R9 keep_mask in reset", keep_mask, 4'hF);
    rst = 1'b0;
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // retention table: R8 R10 R11
    do_reset();
    for (int i = 0; i < 13; i++) begin
      xm_wr      = ROWS[i][10];
      xm_code    = ROWS[i][9:5];
      banks_idle = ROWS[i][4];
      step(1);
      check($sformatf("R8 R10 R11 row %0d", i), keep_mask, ROWS[i][3:0]);
    end
    xm_wr = 0; banks_idle = 1;

    // R1 interval and R2 single grant
    do_reset();
    step(IV - 1);
    check("R1 no request before interval", ref_req, 0);
    step(1);
    check("R1 request at interval", ref_req, 1);
    ref_grant = 1; step(1); ref_grant = 0;
    check("R2 grant clears single request", ref_req, 0);
    step(IV - 2);
    check("R1 quiet before second tick", ref_req, 0);
    step(1);
    check("R1 second tick", ref_req, 1);

    // R2 back-to-back service of three owed refreshes
    do_reset();
    step(3 * IV);
    ref_grant = 1;
    step(1); check("R2 two still owed", ref_req, 1);
    step(1); check("R2 one still owed", ref_req, 1);
    step(1); check("R2 all served", ref_req, 0);
    ref_grant = 0;

    // R3 saturation
    do_reset();
    step(12 * IV);
    ref_grant = 1;
    step(7); check("R3 request after seven grants", ref_req, 1);
    step(1); check("R3 clear after eighth grant", ref_req, 0);
    ref_grant = 0;

    // R4 grant while idle is ignored
    do_reset();
    ref_grant = 1; step(5); ref_grant = 0;
    check("R4 no request after stray grants", ref_req, 0);
    step(IV - 6);
    check("R4 still quiet before tick", ref_req, 0);
    step(1);
    check("R4 tick still produces request", ref_req, 1);
    ref_grant = 1; step(1); ref_grant = 0;
    check("R4 exactly one owed", ref_req, 0);

    // R5 R6 R7 self refresh round trip
    do_reset();
    sr_req = 1; step(1); sr_req = 0;
    check("R5 cke low after entry", cke, 0);
    step(3 * IV);
    check("R6 no request in self refresh", ref_req, 0);
    check("R6 cke held low", cke, 0);
    wake_req = 1; step(1); wake_req = 0;
    check("R7 cke high after wake", cke, 1);
    check("R7 refresh owed after wake", ref_req, 1);
    ref_grant = 1; step(1); ref_grant = 0;
    check("R7 single refresh after wake", ref_req, 0);
    step(IV - 2);
    check("R7 quiet before restarted tick", ref_req, 0);
    step(1);
    check("R7 restarted tick", ref_req, 1);

    // R5 entry waits for owed refresh
    do_reset();
    step(IV);
    sr_req = 1; step(1);
    check("R5 entry blocked while owed", cke, 1);
    ref_grant = 1; step(1); ref_grant = 0;
    check("R5 entry still blocked on grant edge", cke, 1);
    step(1); sr_req = 0;
    check("R5 entry after debt cleared", cke, 0);
    check("R6 request low in self refresh", ref_req, 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule